// File: doc/BRIEF.md
# Burst Read Frame Generator

This block is the burst-read side of a serial register port on an inertial sensor. A host holds chip select low and shifts one 16-bit command. When the command is the burst code, the block freezes a coherent copy of the current sensor outputs. It then streams that copy on the serial output as consecutive 16-bit segments, with no gap between segments and no further command. The stream ends with a 16-bit checksum word.

Three mode inputs shape the stream. One picks 16-bit content, where each axis sends its upper word, or 32-bit content, where each axis sends its lower word and then its upper word. A second picks angular rate and acceleration, or delta angle and delta velocity. A 3-bit clock-mode code picks the trailing word: it is the time stamp when the code is 010, and the sample counter for every other code.

The serial clock is taken in as a one-cycle bit strobe in the system clock domain. On each strobe, the block samples the input bit and then advances the output bit, so the output is stable between strobes and the host reads it just before the next strobe.

Top module: `burst_frame_gen`

## Requirements
- R1: A frame of 0x6800 received while no burst is running starts a burst. Any other value starts nothing, and the following frame returns 0x0000.
- R2: With 16-bit content and rate data, the response words are, in order: status, gyro X/Y/Z upper words, accel X/Y/Z upper words, temperature, counter word, checksum (10 words).
- R3: With the delta select set, delta-angle X/Y/Z replace the gyro words and delta-velocity X/Y/Z replace the accel words, keeping the same X, Y, Z order.
- R4: With 32-bit content, each of the six axis values is sent as bits [15:0] followed by bits [31:16] (16 words in all).
- R5: In 32-bit content, the status, temperature and counter words are each sent once.
- R6: The checksum word equals the modulo-2^16 sum of the upper and lower bytes, each taken as an unsigned 8-bit value, of every word sent before it in the same burst.
- R7: When clock-mode equals 3'b010 at the command frame, the time-stamp input replaces the counter word in every content variant. Every other code sends the sample counter.
- R8: All response words come from the input values present at the end of the command frame. Input changes during the burst do not appear in it.
- R9: Raising chip select during a burst aborts it. The next frame after chip select falls again is decoded as a command.
- R10: The checksum restarts at each burst, so a burst's checksum does not depend on earlier bursts.
- R11: The first response word goes out in the frame right after the command, and later words follow frame after frame with no idle segment. After the checksum frame, and whenever no burst is running, the output returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; high clears the frame and aborts any burst |
| bit_en | input | 1 | One-cycle strobe per serial bit: samples mosi, then advances miso |
| mosi | input | 1 | Serial data in, MSB first |
| miso | output | 1 | Serial data out, MSB first |
| wide_mode | input | 1 | 1 selects 32-bit content per axis |
| delta_sel | input | 1 | 1 selects delta-angle / delta-velocity data |
| clk_mode | input | 3 | Clock-mode code; 3'b010 selects the time stamp as the trailing word |
| status_in | input | 16 | Status word |
| gyro_in | input | 96 | Gyro X/Y/Z, 32 bits each, X at [31:0] |
| accel_in | input | 96 | Accel X/Y/Z, 32 bits each, X at [31:0] |
| dang_in | input | 96 | Delta angle X/Y/Z, 32 bits each, X at [31:0] |
| dvel_in | input | 96 | Delta velocity X/Y/Z, 32 bits each, X at [31:0] |
| temp_in | input | 16 | Temperature word |
| cnt_in | input | 16 | Sample counter word |
| tstamp_in | input | 16 | Time stamp word |

## Verification
The hardest case to reach is a stream that mixes samples: an input that changes after the command frame must not appear in the response. To force it, every burst scrambles all sensor inputs as soon as the command frame ends, and the expected words come from the values held before the scramble.

Aborts are hard to reach too. The bench raises chip select three words into a burst, then sends first a non-burst value and then a burst command. This shows that the decoder goes back to command parsing and that the checksum restarts at the next burst.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int WORD_W = 16;
  localparam int AXES = 6;
  localparam logic [WORD_W-1:0] BURST_CMD = 16'h6800;
  localparam logic [2:0] TSTAMP_MODE = 3'b010;

  typedef logic [AXES-1:0][31:0] axis_set_t;

  // Unsigned sum of the two bytes of a word, widened to a word.
  function automatic logic [WORD_W-1:0] byte_sum(input logic [WORD_W-1:0] w);
    return {8'd0, w[15:8]} + {8'd0, w[7:0]};
  endfunction

  // Number of words that precede the checksum.
  function automatic logic [4:0] data_words(input logic wide);
    return wide ? 5'd15 : 5'd9;
  endfunction

  // Word at position idx of the data part of a burst.
  function automatic logic [WORD_W-1:0] pick_word(input logic [4:0] idx, input logic wide,
                                                  input axis_set_t s, input logic [15:0] stat,
                                                  input logic [15:0] temp, input logic [15:0] ctr);
    logic [4:0] n;
    logic [4:0] k;
    int a;
    n = data_words(wide);
    k = idx - 5'd1;
    if (idx >= n) return '0;
    if (idx == 5'd0) return stat;
    if (idx == n - 5'd2) return temp;
    if (idx == n - 5'd1) return ctr;
    if (wide) begin
      a = int'(k >> 1);
      return k[0] ? s[a][31:16] : s[a][15:0];
    end
    a = int'(k);
    return s[a][31:16];
  endfunction
endpackage

// File: rtl/brf_shifter.sv
module brf_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         bit_en,
  input  logic         mosi,
  input  logic [W-1:0] load_word,
  output logic         miso,
  output logic         frame_done,
  output logic [W-1:0] rx_word
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bitcnt;
  logic [W-1:0]  rx_q;
  logic [W-1:0]  tx_q;

  assign frame_done = bit_en && !cs_n && (bitcnt == LAST);
  assign rx_word    = {rx_q[W-2:0], mosi};
  assign miso       = tx_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else if (cs_n) begin
      bitcnt <= '0;
      tx_q   <= '0;
    end else if (bit_en) begin
      rx_q <= rx_word;
      if (bitcnt == LAST) begin
        bitcnt <= '0;
        tx_q   <= load_word;
      end else begin
        bitcnt <= bitcnt + 1'b1;
        tx_q   <= tx_q << 1;
      end
    end
  end
endmodule

// File: rtl/brf_snapshot.sv
module brf_snapshot
  import brf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic        wide_mode,
  input  logic        delta_sel,
  input  logic [2:0]  clk_mode,
  input  logic [95:0] gyro_in,
  input  logic [95:0] accel_in,
  input  logic [95:0] dang_in,
  input  logic [95:0] dvel_in,
  input  logic [15:0] temp_in,
  input  logic [15:0] cnt_in,
  input  logic [15:0] tstamp_in,
  output axis_set_t   sens,
  output logic [15:0] temp_q,
  output logic [15:0] ctr_q,
  output logic        wide_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sens   <= '0;
      temp_q <= '0;
      ctr_q  <= '0;
      wide_q <= 1'b0;
    end else if (capture) begin
      for (int i = 0; i < 3; i++) begin
        sens[i]   <= delta_sel ? dang_in[32*i +: 32] : gyro_in[32*i +: 32];
        sens[i+3] <= delta_sel ? dvel_in[32*i +: 32] : accel_in[32*i +: 32];
      end
      temp_q <= temp_in;
      ctr_q  <= (clk_mode == TSTAMP_MODE) ? tstamp_in : cnt_in;
      wide_q <= wide_mode;
    end
  end

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(sens) && $stable(ctr_q));
endmodule

// File: rtl/brf_sequencer.sv
module brf_sequencer
  import brf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        frame_done,
  input  logic [15:0] rx_word,
  input  logic [15:0] status_in,
  input  axis_set_t   sens,
  input  logic [15:0] temp_q,
  input  logic [15:0] ctr_q,
  input  logic        wide_q,
  output logic        start,
  output logic        active,
  output logic [15:0] load_word
);
  logic [4:0]  idx;
  logic [4:0]  n_data;
  logic [15:0] csum;
  logic [15:0] stat_q;

  assign n_data = data_words(wide_q);
  assign start  = frame_done && !active && (rx_word == BURST_CMD);

  always_comb begin
    if (start)                          load_word = status_in;
    else if (active && idx < n_data)    load_word = pick_word(idx, wide_q, sens, stat_q, temp_q, ctr_q);
    else if (active && idx == n_data)   load_word = csum;
    else                                load_word = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      csum   <= '0;
      stat_q <= '0;
    end else if (cs_n) begin
      active <= 1'b0;
      idx    <= '0;
      csum   <= '0;
    end else if (frame_done) begin
      if (start) begin
        active <= 1'b1;
        idx    <= 5'd1;
        csum   <= byte_sum(status_in);
        stat_q <= status_in;
      end else if (active) begin
        if (idx < n_data) begin
          csum <= csum + byte_sum(load_word);
          idx  <= idx + 5'd1;
        end else if (idx == n_data) begin
          idx <= idx + 5'd1;
        end else begin
          active <= 1'b0;
          idx    <= '0;
        end
      end
    end
  end

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cs_n) |=> active && idx == 5'd1);
  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !active);
  // R11
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> idx <= n_data + 5'd1);
  // R6
  csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frame_done && !cs_n) |=> $stable(csum));
endmodule

// File: rtl/burst_frame_gen.sv
module burst_frame_gen
  import brf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        bit_en,
  input  logic        mosi,
  output logic        miso,
  input  logic        wide_mode,
  input  logic        delta_sel,
  input  logic [2:0]  clk_mode,
  input  logic [15:0] status_in,
  input  logic [95:0] gyro_in,
  input  logic [95:0] accel_in,
  input  logic [95:0] dang_in,
  input  logic [95:0] dvel_in,
  input  logic [15:0] temp_in,
  input  logic [15:0] cnt_in,
  input  logic [15:0] tstamp_in
);
  logic        frame_done;
  logic [15:0] rx_word;
  logic [15:0] load_word;
  logic        start;
  logic        active;
  axis_set_t   sens;
  logic [15:0] temp_q;
  logic [15:0] ctr_q;
  logic        wide_q;

  brf_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_en(bit_en), .mosi(mosi),
    .load_word(load_word), .miso(miso), .frame_done(frame_done), .rx_word(rx_word)
  );

  brf_snapshot u_snap (
    .clk(clk), .rst_n(rst_n), .capture(start), .wide_mode(wide_mode),
    .delta_sel(delta_sel), .clk_mode(clk_mode), .gyro_in(gyro_in),
    .accel_in(accel_in), .dang_in(dang_in), .dvel_in(dvel_in),
    .temp_in(temp_in), .cnt_in(cnt_in), .tstamp_in(tstamp_in),
    .sens(sens), .temp_q(temp_q), .ctr_q(ctr_q), .wide_q(wide_q)
  );

  brf_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .frame_done(frame_done),
    .rx_word(rx_word), .status_in(status_in), .sens(sens), .temp_q(temp_q),
    .ctr_q(ctr_q), .wide_q(wide_q), .start(start), .active(active),
    .load_word(load_word)
  );

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || (!active && !start)) |=> !(active) || !cs_n);
endmodule

// File: tb/burst_frame_gen_tb.sv
module burst_frame_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        bit_en = 1'b0;
  logic        mosi = 1'b0;
  logic        miso;
  logic        wide_mode = 1'b0;
  logic        delta_sel = 1'b0;
  logic [2:0]  clk_mode = 3'b000;
  logic [15:0] status_in = '0, temp_in = '0, cnt_in = '0, tstamp_in = '0;
  logic [31:0] g [3], ac [3], da [3], dv [3];
  logic [95:0] gyro_in, accel_in, dang_in, dvel_in;
  int nchk = 0;
  int nerr = 0;

  assign gyro_in  = {g[2], g[1], g[0]};
  assign accel_in = {ac[2], ac[1], ac[0]};
  assign dang_in  = {da[2], da[1], da[0]};
  assign dvel_in  = {dv[2], dv[1], dv[0]};

  always #4 clk = ~clk;

  burst_frame_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_en(bit_en), .mosi(mosi), .miso(miso),
    .wide_mode(wide_mode), .delta_sel(delta_sel), .clk_mode(clk_mode),
    .status_in(status_in), .gyro_in(gyro_in), .accel_in(accel_in),
    .dang_in(dang_in), .dvel_in(dvel_in), .temp_in(temp_in),
    .cnt_in(cnt_in), .tstamp_in(tstamp_in)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] seed);
    status_in = {seed, 8'hC3};
    temp_in   = {8'h1E, seed ^ 8'h77};
    cnt_in    = {seed, 8'h0C};
    tstamp_in = {8'hE7, seed};
    for (int i = 0; i < 3; i++) begin
      g[i]  = {8'h10 + 8'(i), seed, 8'h20 + 8'(i), ~seed};
      ac[i] = {8'h30 + 8'(i), ~seed, 8'h40 + 8'(i), seed};
      da[i] = {8'h50 + 8'(i), seed ^ 8'hF0, 8'h60 + 8'(i), seed};
      dv[i] = {8'hF8 - 8'(i), seed, 8'h80 + 8'(i), seed ^ 8'h0F};
    end
  endtask

  task automatic xfer(input logic [15:0] dout, output logic [15:0] din);
    for (int b = 15; b >= 0; b--) begin
      mosi = dout[b];
      @(negedge clk);
      din[b] = miso;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  // Runs a complete burst and checks every word plus the quiet frame after it.
  task automatic run_burst(input logic wide, input logic delta, input logic [2:0] mode,
                           input logic [7:0] seed, input string tag);
    logic [15:0] exp [17];
    logic [15:0] got;
    logic [15:0] sum;
    logic [31:0] v;
    int k;
    wide_mode = wide; delta_sel = delta; clk_mode = mode;
    fill(seed);
    k = 0;
    exp[k] = status_in; k++;
    for (int a = 0; a < 6; a++) begin
      if (a < 3) v = delta ? da[a] : g[a];
      else       v = delta ? dv[a-3] : ac[a-3];
      if (wide) begin exp[k] = v[15:0]; k++; end
      exp[k] = v[31:16]; k++;
    end
    exp[k] = temp_in; k++;
    exp[k] = (mode == 3'b010) ? tstamp_in : cnt_in; k++;
    sum = 16'h0;
    for (int j = 0; j < k; j++) sum = sum + 16'(exp[j][15:8]) + 16'(exp[j][7:0]);
    exp[k] = sum;
    @(negedge clk); cs_n = 1'b0;
    xfer(16'h6800, got);
    fill(seed ^ 8'h5A);            // R8: inputs move during the burst
    wide_mode = ~wide; delta_sel = ~delta; clk_mode = ~mode;
    for (int j = 0; j <= k; j++) begin
      xfer(16'h0000, got);
      if (j == k)                       chk({tag, " R6 R10 checksum"}, got, exp[j]);
      else if (j == k - 1)              chk({tag, " R7 counter word"}, got, exp[j]);
      else                              chk({tag, $sformatf(" R8 word %0d", j)}, got, exp[j]);
    end
    xfer(16'h0000, got);
    chk({tag, " R11 quiet after checksum"}, got, 16'h0000);
    @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 reset miso", {15'd0, miso}, 16'h0000);
  endtask

  task automatic t_bad_cmd();
    logic [15:0] got;
    @(negedge clk); cs_n = 1'b0;
    xfer(16'h6801, got);
    xfer(16'h0000, got);
    chk("R1 non-burst value ignored", got, 16'h0000);
    xfer(16'h4800, got);
    xfer(16'h0000, got);
    chk("R1 other value ignored", got, 16'h0000);
    @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_abort();
    logic [15:0] got;
    wide_mode = 1'b0; delta_sel = 1'b0; clk_mode = 3'b000;
    fill(8'h99);
    @(negedge clk); cs_n = 1'b0;
    xfer(16'h6800, got);
    xfer(16'h0000, got);
    chk("R9 first word before abort", got, status_in);
    xfer(16'h0000, got);
    xfer(16'h0000, got);
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    xfer(16'h1234, got);
    chk("R9 aborted burst sends nothing", got, 16'h0000);
    xfer(16'h0000, got);
    chk("R9 non-command after abort", got, 16'h0000);
    @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
    run_burst(1'b0, 1'b0, 3'b000, 8'h3C, "R9 R10 after abort");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    fill(8'h00);
    run_burst(1'b0, 1'b0, 3'b000, 8'h11, "R2 narrow rate");
    run_burst(1'b0, 1'b1, 3'b001, 8'h22, "R3 narrow delta");
    run_burst(1'b1, 1'b0, 3'b000, 8'h33, "R4 R5 wide rate");
    run_burst(1'b1, 1'b1, 3'b101, 8'hFF, "R4 R5 wide delta");
    run_burst(1'b0, 1'b0, 3'b010, 8'h44, "R7 narrow tstamp");
    run_burst(1'b1, 1'b1, 3'b010, 8'hEE, "R7 wide tstamp");
    t_bad_cmd();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule